// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block is a management-bus slave. It lets an MDIO master reach a 32-bit register space with 19-bit byte addresses while sending nothing but ordinary Clause-22 frames. The frame's 5-bit PHY-address field is split in two. Its top two bits select an access mode, and its low three bits together with the 5-bit register field carry part of the register address. The upper address bits come from a page register that is loaded by a separate frame.

Each 32-bit register is reached as two 16-bit halves. The low half sits at byte address A and the high half at A+2. A write of the low half only stages the data. The write of the high half commits the whole word to the internal register bus in one transfer. A read of the low half fetches the whole word, returns its low 16 bits and keeps the upper 16 bits for a following read of the high half. A separate mode hands frames to the internal PHYs through a 16-bit bypass handshake. The block samples MDC and MDIO with the fast system clock and drives read data onto MDIO during the turnaround and data phases.

Top module: `mdio_page_bridge`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive preamble ones, followed by start bits 0 then 1 and an opcode of 10 (read) or 01 (write). A frame with a short preamble or any other opcode causes no bus or bypass transfer, and MDIO is not driven for it.
- R2: Bits 4:3 of the PHY-address field select the mode: 3 is page, 2 is register, 0 is bypass. A frame with mode 1 has no effect on the page, the buses or the staged data, and MDIO is not driven for it.
- R3: A page-mode write loads data bits 9:0 into the page register, which supplies bus address bits 18:9. Only a page-mode write changes the page.
- R4: In register mode the bus address is {page, PHY-address bits 2:0, register bits 4:1, 2'b00}. Register bit 0 picks the half: 0 is the low half (A) and 1 is the high half (A+2).
- R5: A register-mode write to a low half stores its 16 bits and starts no bus transfer. A write to the high half starts exactly one bus write with data {high half, stored low half}.
- R6: A register-mode read of a low half starts one bus read, returns bits 15:0 and keeps bits 31:16. A read of a high half returns the kept bits and starts no bus transfer.
- R7: For an accepted read, MDIO is released during the first turnaround bit, driven 0 during the second, then carries 16 data bits MSB first, and is released after the last data bit.
- R8: A page-mode read is not answered: MDIO stays released, because the page cannot be read back.
- R9: In bypass mode, a read starts a bypass read to PHY (PHY-address bits 2:0) and register (the 5-bit register field) and returns its 16-bit data on MDIO. A write passes its 16-bit data to that PHY and register.
- R10: Reset clears the page, the staged low half and the kept upper half, releases MDIO and drops both request outputs.
- R11: A bus or bypass request stays high, with stable address, direction and data, until the matching acknowledge. Each committing access makes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the MDIO master |
| mdio_i | input | 1 | MDIO line level as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the bridge |
| mdio_oe | output | 1 | MDIO output enable |
| bus_req | output | 1 | Register-bus request, held until acknowledge |
| bus_we | output | 1 | Register-bus direction, 1 = write |
| bus_addr | output | 19 | Register-bus byte address, word aligned |
| bus_wdata | output | 32 | Register-bus write data |
| bus_ack | input | 1 | Register-bus acknowledge, one cycle |
| bus_rdata | input | 32 | Register-bus read data, valid with acknowledge |
| byp_req | output | 1 | Bypass request to the internal PHYs |
| byp_we | output | 1 | Bypass direction, 1 = write |
| byp_phy | output | 3 | Bypass PHY number |
| byp_reg | output | 5 | Bypass PHY register number |
| byp_wdata | output | 16 | Bypass write data |
| byp_ack | input | 1 | Bypass acknowledge, one cycle |
| byp_rdata | input | 16 | Bypass read data, valid with acknowledge |

## Verification
Some rules hold on every cycle, and the assertions check those. A request holds its address and direction until acknowledged. Bus addresses stay word aligned. Only a page-mode write changes the page. MDIO is driven only for an accepted read in register or bypass mode, and every drive starts with a turnaround zero. The values themselves can only be shown by the bench's scenarios. These are the way page, PHY bits and register bits combine into a bus address, the staged low half merging into the committed word, and the kept upper half returned on the next read. The scenarios also show that ignored frames (mode 1, bad opcode, short preamble, page read) leave the buses quiet, and that reset clears the page and the staged data.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int HDR_W  = 12;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [1:0] {
    MD_BYPASS = 2'd0,
    MD_RSVD   = 2'd1,
    MD_REG    = 2'd2,
    MD_PAGE   = 2'd3
  } mdio_mode_e;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_hdr_t;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[s] <= '0;
        end else if (s == 0) begin
          chain[s] <= d;
        end else begin
          chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc_s,
  input  logic              mdio_s,
  output logic              hdr_valid,
  output mdio_hdr_t         hdr,
  output logic              wr_valid,
  output logic [HALF_W-1:0] wr_data,
  input  logic              hdr_drive,
  input  logic [HALF_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);

  typedef enum logic {S_IDLE, S_RUN} fr_state_e;

  fr_state_e         state;
  logic              mdc_d;
  logic              rise, fall;
  logic [PRE_W-1:0]  pre_cnt;
  logic [5:0]        cnt;
  logic [HDR_W-1:0]  hdr_sh;
  logic [HALF_W-1:0] tx_sh;
  logic [1:0]        op_nxt;

  assign rise   = mdc_s & ~mdc_d;
  assign fall   = ~mdc_s & mdc_d;
  assign op_nxt = hdr_sh[10:9];
  assign hdr    = {(hdr_sh[11:10] == OP_RD), hdr_sh[9:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mdc_d     <= 1'b0;
      pre_cnt   <= '0;
      cnt       <= '0;
      hdr_sh    <= '0;
      wr_data   <= '0;
      tx_sh     <= '0;
      hdr_valid <= 1'b0;
      wr_valid  <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe   <= 1'b0;
    end else begin
      mdc_d     <= mdc_s;
      hdr_valid <= 1'b0;
      wr_valid  <= 1'b0;
      if (rise) begin
        if (state == S_IDLE) begin
          if (mdio_s) begin
            if (pre_cnt != PRE_W'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt == PRE_W'(PRE_LEN)) begin
            state   <= S_RUN;
            cnt     <= 6'd1;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == 6'd1 && !mdio_s) state <= S_IDLE;
          if (cnt >= 6'd2 && cnt <= 6'd13) hdr_sh <= {hdr_sh[HDR_W-2:0], mdio_s};
          if (cnt == 6'd13) begin
            if (op_nxt == OP_RD || op_nxt == OP_WR) hdr_valid <= 1'b1;
            else state <= S_IDLE;
          end
          if (cnt >= 6'd16 && cnt <= 6'd31) wr_data <= {wr_data[HALF_W-2:0], mdio_s};
          if (cnt == 6'd31 && !hdr.rd) wr_valid <= 1'b1;
        end
      end
      if (fall && state == S_RUN) begin
        if (cnt == 6'd15 && hdr.rd && hdr_drive) begin
          mdio_oe <= 1'b1;
          mdio_o  <= 1'b0;
          tx_sh   <= rd_data;
        end else if (cnt >= 6'd16 && cnt <= 6'd31 && mdio_oe) begin
          mdio_o <= tx_sh[HALF_W-1];
          tx_sh  <= {tx_sh[HALF_W-2:0], 1'b0};
        end else if (cnt >= 6'd32) begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
          state   <= S_IDLE;
        end
      end
    end
  end

  AST_OE_ACCEPTED_READ: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (hdr.rd && hdr_drive)); // R8
  AST_TA_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o); // R7
  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (rst)
    !(hdr_valid && wr_valid)); // R1
endmodule

// File: rtl/mdio_cmd_core.sv
module mdio_cmd_core
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int ADDR_W = PAGE_W + 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  mdio_hdr_t         hdr,
  input  logic              wr_valid,
  input  logic [HALF_W-1:0] wr_data,
  output logic              hdr_drive,
  output logic [HALF_W-1:0] rd_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              byp_req,
  output logic              byp_we,
  output logic [2:0]        byp_phy,
  output logic [4:0]        byp_reg,
  output logic [HALF_W-1:0] byp_wdata,
  input  logic              byp_ack,
  input  logic [HALF_W-1:0] byp_rdata
);
  mdio_mode_e        mode;
  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] stage_lo;
  logic [HALF_W-1:0] upper_keep;
  logic [ADDR_W-1:0] word_addr;

  assign mode      = mdio_mode_e'(hdr.phy[4:3]);
  assign hdr_drive = hdr.rd && (mode == MD_REG || mode == MD_BYPASS);
  assign word_addr = {page, hdr.phy[2:0], hdr.regn[4:1], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      page       <= '0;
      stage_lo   <= '0;
      upper_keep <= '0;
      rd_data    <= '0;
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      byp_req    <= 1'b0;
      byp_we     <= 1'b0;
      byp_phy    <= '0;
      byp_reg    <= '0;
      byp_wdata  <= '0;
    end else begin
      if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        if (!bus_we) begin
          rd_data    <= bus_rdata[HALF_W-1:0];
          upper_keep <= bus_rdata[WORD_W-1:HALF_W];
        end
      end
      if (byp_req && byp_ack) begin
        byp_req <= 1'b0;
        if (!byp_we) rd_data <= byp_rdata;
      end
      if (hdr_valid && hdr.rd) begin
        case (mode)
          MD_REG: begin
            if (!hdr.regn[0]) begin
              bus_req  <= 1'b1;
              bus_we   <= 1'b0;
              bus_addr <= word_addr;
            end else begin
              rd_data <= upper_keep;
            end
          end
          MD_BYPASS: begin
            byp_req <= 1'b1;
            byp_we  <= 1'b0;
            byp_phy <= hdr.phy[2:0];
            byp_reg <= hdr.regn;
          end
          default: ;
        endcase
      end
      if (wr_valid) begin
        case (mode)
          MD_PAGE: page <= wr_data[PAGE_W-1:0];
          MD_REG: begin
            if (!hdr.regn[0]) begin
              stage_lo <= wr_data;
            end else begin
              bus_req   <= 1'b1;
              bus_we    <= 1'b1;
              bus_addr  <= word_addr;
              bus_wdata <= {wr_data, stage_lo};
            end
          end
          MD_BYPASS: begin
            byp_req   <= 1'b1;
            byp_we    <= 1'b1;
            byp_phy   <= hdr.phy[2:0];
            byp_reg   <= hdr.regn;
            byp_wdata <= wr_data;
          end
          default: ;
        endcase
      end
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R11
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (byp_req && !byp_ack) |=> (byp_req && $stable(byp_phy) && $stable(byp_reg))); // R11
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_addr[1:0] == 2'b00)); // R4
  AST_PAGE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !$stable(page) |-> $past(wr_valid && mode == MD_PAGE)); // R3
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && byp_req)); // R9
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W      = 10,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = PAGE_W + 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              byp_req,
  output logic              byp_we,
  output logic [2:0]        byp_phy,
  output logic [4:0]        byp_reg,
  output logic [15:0]       byp_wdata,
  input  logic              byp_ack,
  input  logic [15:0]       byp_rdata
);
  logic [1:0]        sync_q;
  logic              hdr_valid, wr_valid, hdr_drive;
  mdio_hdr_t         hdr;
  logic [HALF_W-1:0] wr_data, rd_data;

  mdio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mdc, mdio_i}),
    .q   (sync_q)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .mdc_s     (sync_q[1]),
    .mdio_s    (sync_q[0]),
    .hdr_valid (hdr_valid),
    .hdr       (hdr),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .hdr_drive (hdr_drive),
    .rd_data   (rd_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  mdio_cmd_core #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .hdr_valid (hdr_valid),
    .hdr       (hdr),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .hdr_drive (hdr_drive),
    .rd_data   (rd_data),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .byp_req   (byp_req),
    .byp_we    (byp_we),
    .byp_phy   (byp_phy),
    .byp_reg   (byp_reg),
    .byp_wdata (byp_wdata),
    .byp_ack   (byp_ack),
    .byp_rdata (byp_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!mdio_oe && !bus_req && !byp_req)); // R10
endmodule

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b1;
  logic        mdio_m = 1'b1;
  logic        mdio_o, mdio_oe;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [18:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic        byp_req, byp_we, byp_ack = 1'b0;
  logic [2:0]  byp_phy;
  logic [4:0]  byp_reg;
  logic [15:0] byp_wdata, byp_rdata = '0;
  wire         mdio_line = mdio_oe ? mdio_o : mdio_m;

  int checks = 0, errors = 0;
  int bus_rd_cnt = 0, bus_wr_cnt = 0, byp_rd_cnt = 0, byp_wr_cnt = 0;
  logic [18:0] last_raddr = '0, last_waddr = '0;
  logic [31:0] last_wdata = '0;
  logic [2:0]  last_bphy = '0;
  logic [4:0]  last_breg = '0;
  logic [15:0] last_bdata = '0;
  int bus_wait = 0, byp_wait = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mdio_page_bridge u_dut (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .byp_req(byp_req), .byp_we(byp_we), .byp_phy(byp_phy), .byp_reg(byp_reg),
    .byp_wdata(byp_wdata), .byp_ack(byp_ack), .byp_rdata(byp_rdata)
  );

  function automatic logic [31:0] bus_model(input logic [18:0] a);
    return {a[15:0] ^ 16'h5AC3, a[15:0]};
  endfunction

  // responders act at the falling clock edge
  always @(negedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; byp_ack <= 1'b0; bus_wait <= 0; byp_wait <= 0;
    end else begin
      if (bus_ack) bus_ack <= 1'b0;
      else if (bus_req) begin
        if (bus_wait == 2) begin
          bus_ack <= 1'b1; bus_wait <= 0;
          if (bus_we) begin
            bus_wr_cnt <= bus_wr_cnt + 1; last_waddr <= bus_addr; last_wdata <= bus_wdata;
          end else begin
            bus_rd_cnt <= bus_rd_cnt + 1; last_raddr <= bus_addr; bus_rdata <= bus_model(bus_addr);
          end
        end else bus_wait <= bus_wait + 1;
      end
      if (byp_ack) byp_ack <= 1'b0;
      else if (byp_req) begin
        if (byp_wait == 3) begin
          byp_ack <= 1'b1; byp_wait <= 0;
          last_bphy <= byp_phy; last_breg <= byp_reg;
          if (byp_we) begin
            byp_wr_cnt <= byp_wr_cnt + 1; last_bdata <= byp_wdata;
          end else begin
            byp_rd_cnt <= byp_rd_cnt + 1; byp_rdata <= {byp_phy, byp_reg, 8'hA6};
          end
        end else byp_wait <= byp_wait + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic b, output logic sv, output logic so);
    mdc = 1'b0; mdio_m = b;
    repeat (HALF) @(negedge clk);
    sv = mdio_line; so = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, output logic [15:0] rd, output logic ta_ok, output logic drove);
    logic sv, so;
    logic [13:0] head;
    head = {2'b01, op, phy, rg};
    rd = '0; ta_ok = 1'b1; drove = 1'b0;
    for (int i = 0; i < pre; i++) begin bit_cyc(1'b1, sv, so); drove |= so; end
    for (int i = 13; i >= 0; i--) begin bit_cyc(head[i], sv, so); drove |= so; end
    if (op == 2'b10) begin
      bit_cyc(1'b1, sv, so); drove |= so; if (so) ta_ok = 1'b0;
      bit_cyc(1'b1, sv, so); drove |= so; if (!so || sv) ta_ok = 1'b0;
      for (int i = 0; i < 16; i++) begin
        bit_cyc(1'b1, sv, so); drove |= so; if (!so) ta_ok = 1'b0; rd = {rd[14:0], sv};
      end
    end else begin
      bit_cyc(1'b1, sv, so); drove |= so;
      bit_cyc(1'b0, sv, so); drove |= so;
      for (int i = 15; i >= 0; i--) begin bit_cyc(wd[i], sv, so); drove |= so; end
    end
    for (int i = 0; i < 2; i++) begin
      bit_cyc(1'b1, sv, so); if (so) begin ta_ok = 1'b0; drove = 1'b1; end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10", "oe after reset", {31'b0, mdio_oe}, 32'd0);
    check("R10", "bus_req after reset", {31'b0, bus_req}, 32'd0);
    check("R10", "byp_req after reset", {31'b0, byp_req}, 32'd0);
  endtask

  task automatic t_reg_read;
    logic [15:0] rd; logic ok, dr; int n;
    n = bus_rd_cnt;
    frame(32, 2'b10, {2'b10, 3'd3}, 5'd4, 16'h0, rd, ok, dr);
    check("R4", "read address page0", {13'b0, last_raddr}, 32'h000C8);
    check("R6", "low half data", {16'b0, rd}, 32'h00C8);
    check("R7", "turnaround and drive window", {31'b0, ok}, 32'd1);
    check("R11", "one bus read", n + 1, bus_rd_cnt);
    frame(32, 2'b10, {2'b10, 3'd3}, 5'd5, 16'h0, rd, ok, dr);
    check("R6", "high half from kept word", {16'b0, rd}, 32'h00C8 ^ 32'h5AC3);
    check("R6", "no bus read for high half", n + 1, bus_rd_cnt);
  endtask

  task automatic t_page_and_write;
    logic [15:0] rd; logic ok, dr; int n;
    n = bus_wr_cnt;
    frame(32, 2'b01, {2'b11, 3'd0}, 5'd0, 16'hFEAB, rd, ok, dr);
    check("R3", "page write makes no transfer", bus_wr_cnt, n);
    frame(32, 2'b01, {2'b10, 3'd1}, 5'd6, 16'h1234, rd, ok, dr);
    check("R5", "low half staged only", bus_wr_cnt, n);
    frame(32, 2'b01, {2'b10, 3'd1}, 5'd7, 16'hBEEF, rd, ok, dr);
    check("R5", "high half commits once", bus_wr_cnt, n + 1);
    check("R3", "paged write address", {13'b0, last_waddr}, 32'h5564C);
    check("R5", "merged write data", last_wdata, 32'hBEEF1234);
    frame(32, 2'b10, {2'b11, 3'd0}, 5'd0, 16'h0, rd, ok, dr);
    check("R8", "page read not driven", {31'b0, dr}, 32'd0);
    frame(32, 2'b10, {2'b10, 3'd0}, 5'd0, 16'h0, rd, ok, dr);
    check("R3", "paged read address", {13'b0, last_raddr}, 32'h55600);
  endtask

  task automatic t_mode1;
    logic [15:0] rd; logic ok, dr; int nr, nw, br, bw;
    nr = bus_rd_cnt; nw = bus_wr_cnt; br = byp_rd_cnt; bw = byp_wr_cnt;
    frame(32, 2'b01, {2'b01, 3'd2}, 5'd0, 16'h0001, rd, ok, dr);
    frame(32, 2'b01, {2'b01, 3'd2}, 5'd7, 16'hCAFE, rd, ok, dr);
    frame(32, 2'b10, {2'b01, 3'd2}, 5'd2, 16'h0, rd, ok, dr);
    check("R2", "mode 1 read not driven", {31'b0, dr}, 32'd0);
    check("R2", "mode 1 no transfers", nr + nw + br + bw, bus_rd_cnt + bus_wr_cnt + byp_rd_cnt + byp_wr_cnt);
    frame(32, 2'b10, {2'b10, 3'd7}, 5'd2, 16'h0, rd, ok, dr);
    check("R2", "page kept after mode 1", {13'b0, last_raddr}, 32'h557C4);
  endtask

  task automatic t_bad_frames;
    logic [15:0] rd; logic ok, dr; int nr, nw;
    nr = bus_rd_cnt; nw = bus_wr_cnt;
    frame(32, 2'b00, {2'b10, 3'd0}, 5'd1, 16'h0000, rd, ok, dr);
    check("R1", "bad opcode no write", bus_wr_cnt, nw);
    frame(32, 2'b01, {2'b10, 3'd0}, 5'd2, 16'h0F0F, rd, ok, dr);
    frame(20, 2'b10, {2'b10, 3'd0}, 5'd0, 16'h0, rd, ok, dr);
    check("R1", "short preamble read not driven", {31'b0, dr}, 32'd0);
    check("R1", "short preamble no read", bus_rd_cnt, nr);
  endtask

  task automatic t_bypass;
    logic [15:0] rd; logic ok, dr; int n;
    n = byp_wr_cnt;
    frame(32, 2'b10, {2'b00, 3'd5}, 5'd9, 16'h0, rd, ok, dr);
    check("R9", "bypass read data", {16'b0, rd}, {16'b0, 3'd5, 5'd9, 8'hA6});
    check("R9", "bypass read window", {31'b0, ok}, 32'd1);
    frame(32, 2'b01, {2'b00, 3'd2}, 5'd17, 16'h7E11, rd, ok, dr);
    check("R9", "bypass write count", byp_wr_cnt, n + 1);
    check("R9", "bypass write target", {24'b0, last_bphy, last_breg}, {24'b0, 3'd2, 5'd17});
    check("R9", "bypass write data", {16'b0, last_bdata}, 32'h7E11);
  endtask

  task automatic t_reset_mid;
    logic [15:0] rd; logic ok, dr;
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk); rst = 1'b0;
    check("R10", "oe after mid reset", {31'b0, mdio_oe}, 32'd0);
    frame(32, 2'b01, {2'b10, 3'd0}, 5'd1, 16'h00AA, rd, ok, dr);
    check("R10", "page cleared by reset", {13'b0, last_waddr}, 32'h0);
    check("R10", "staged half cleared", last_wdata, 32'h00AA0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reg_read();
    t_page_and_write();
    t_mode1();
    t_bad_frames();
    t_bypass();
    t_reset_mid();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule